// File: doc/BRIEF.md
# Smart Card Contact Deactivation Sequencer

This block takes one smart card slot from the powered state to the fully deactivated state in a fixed order. A slot has one instance. The block runs on its own deactivation clock, and every step is timed in units of a base delay equal to eight clock periods. Four synchronous level requests can start a sequence: the slot's reset pin going low, an early power-fail warning, a software reset and a software voltage-error request. A started sequence always runs to its end. Further requests, repeated requests and changes of the mode select do not alter its timing.

The card reset line is pulled low and the shutdown status bit is set first. Five units later the card clock stops, the clock-stop and I/O-disable flags rise, and the I/O line is driven high. One unit after that the I/O line is driven low. One more unit later the supply select drops to 00, which turns the card supply off, and the done flag rises. In the alternate clock mode the first gap is 5.5 units and the second gap is 0.5 units. The supply still switches off at the same point. A separate emergency power-fail input forces every output to its deactivated value on the next clock from any state, which cuts short any sequence in progress. A re-arm pulse given while no request is active clears the done flag and lets a new sequence start. The outputs stay deactivated.

Top module: `sc_deact_seq`

## Requirements
- R1: In reset the outputs are card_rst=1 (released), card_clk_en=1 (clock running), clk_stop=0, card_io=0, io_dis=0, vsel=VSEL_ON (default 2'b10), shutdown=0 and seq_done=0.
- R2: Take T0 as the clock edge at which any of the four start requests is high while the block is idle. After T0, card_rst=0 and shutdown=1. Each of the four requests starts the sequence on its own.
- R3: In the normal mode, the edge at T0+40 clocks sets card_clk_en=0 and clk_stop=1, drives card_io=1 and sets io_dis=1. None of these change before that edge.
- R4: card_io returns to 0 at the edge at T0+48 clocks.
- R5: vsel becomes 2'b00 and seq_done becomes 1 at the edge at T0+56 clocks, and not before.
- R6: In the alternate clock mode (alt_clk_mode=1 at T0), the clock-stop step moves to T0+44 clocks. The I/O-low step stays at T0+48 and the supply-off step stays at T0+56.
- R7: Requests that are held or repeated during a sequence, or after it has ended, do not restart it or change its timing.
- R8: alt_clk_mode is sampled only at T0. Changing it while the sequence runs has no effect.
- R9: When emerg_pf is high at an edge, in any state, the outputs after that edge are card_rst=0, card_clk_en=0, clk_stop=1, card_io=0, io_dis=1, vsel=2'b00, shutdown=1 and seq_done=1.
- R10: seq_done stays 1 until a rearm is sampled while no start request is high. rearm together with an active request is ignored, and so is rearm during a sequence. After a valid rearm, seq_done=0, the other outputs keep their deactivated values, and a new request starts a sequence that again ends at T0+56.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Deactivation clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_low_req | input | 1 | Slot reset pin is low (start request) |
| pwr_warn_req | input | 1 | Early power-fail warning (start request) |
| sw_reset_req | input | 1 | Software reset (start request) |
| sw_verr_req | input | 1 | Software voltage-error request (start request) |
| emerg_pf | input | 1 | Emergency power fail: immediate full deactivation |
| alt_clk_mode | input | 1 | Selects the alternate half-unit step timing |
| rearm | input | 1 | Returns a finished block to idle |
| card_rst | output | 1 | Card reset line, 0 = reset asserted |
| card_clk_en | output | 1 | Card clock enable, 1 = clock running |
| clk_stop | output | 1 | Clock-stopped flag |
| card_io | output | 1 | Level driven on the card I/O line |
| io_dis | output | 1 | I/O disable flag |
| vsel | output | 2 | Card supply select, 00 = supply off |
| shutdown | output | 1 | Shutdown status bit |
| seq_done | output | 1 | Deactivation complete |

## Verification
The hardest cases to reach are an emergency that lands on an exact clock of a running sequence, and in particular on the edge where a normal step would also fire. The bench starts a sequence and raises emerg_pf at every offset from T0 through T0+57, checking the forced outputs one edge later each time. Held requests and a mode select that flips halfway through a sequence show that neither restarts the sequence nor moves its timing. The re-arm path is reached by running a sequence to completion and then giving rearm first with a request still high and then with no request.

// File: rtl/sc_deact_pkg.sv
package sc_deact_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_LOW,
        ST_CLK_STOP,
        ST_IO_LOW,
        ST_DONE
    } seq_state_e;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_T0,
        EV_CLK,
        EV_IO,
        EV_VCC,
        EV_EMERG
    } step_ev_e;

    typedef struct packed {
        logic       rst_n;
        logic       clk_en;
        logic       clk_stop;
        logic       io;
        logic       io_dis;
        logic [1:0] vsel;
        logic       shutdown;
    } card_drv_t;

    // Gap from T0 to the clock-stop step, in clocks
    function automatic int gap_first(input int td, input logic alt);
        return alt ? (5 * td + td / 2) : (5 * td);
    endfunction

    // Gap from the clock-stop step to the I/O-low step
    function automatic int gap_second(input int td, input logic alt);
        return alt ? (td / 2) : td;
    endfunction

    // Gap from the I/O-low step to supply off
    function automatic int gap_third(input int td);
        return td;
    endfunction

    function automatic card_drv_t drv_powered(input logic [1:0] von);
        card_drv_t d;
        d.rst_n    = 1'b1;
        d.clk_en   = 1'b1;
        d.clk_stop = 1'b0;
        d.io       = 1'b0;
        d.io_dis   = 1'b0;
        d.vsel     = von;
        d.shutdown = 1'b0;
        return d;
    endfunction

    function automatic card_drv_t drv_final();
        card_drv_t d;
        d.rst_n    = 1'b0;
        d.clk_en   = 1'b0;
        d.clk_stop = 1'b1;
        d.io       = 1'b0;
        d.io_dis   = 1'b1;
        d.vsel     = 2'b00;
        d.shutdown = 1'b1;
        return d;
    endfunction

    function automatic card_drv_t drv_step(input card_drv_t cur, input step_ev_e ev);
        card_drv_t d;
        d = cur;
        case (ev)
            EV_T0: begin
                d.rst_n    = 1'b0;
                d.shutdown = 1'b1;
            end
            EV_CLK: begin
                d.clk_en   = 1'b0;
                d.clk_stop = 1'b1;
                d.io       = 1'b1;
                d.io_dis   = 1'b1;
            end
            EV_IO:    d.io   = 1'b0;
            EV_VCC:   d.vsel = 2'b00;
            EV_EMERG: d      = drv_final();
            default:  d      = cur;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/sc_deact_trig.sv
module sc_deact_trig #(
    parameter int NSRC = 4
) (
    input  logic [NSRC-1:0] req,
    output logic            any_req
);
    logic [NSRC:0] chain;

    assign chain[0] = 1'b0;
    for (genvar i = 0; i < NSRC; i++) begin : g_or
        assign chain[i+1] = chain[i] | req[i];
    end
    assign any_req = chain[NSRC];
endmodule

// File: rtl/sc_deact_timer.sv
module sc_deact_timer #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sc_deact_fsm.sv
module sc_deact_fsm
    import sc_deact_pkg::*;
#(
    parameter int TD_CLKS = 8,
    parameter int CW      = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          emerg,
    input  logic          alt_mode,
    input  logic          rearm,
    input  logic          expired,
    output logic          load,
    output logic [CW-1:0] load_val,
    output step_ev_e      ev,
    output logic          done
);
    localparam logic [CW-1:0] L1_NORM = CW'(gap_first(TD_CLKS, 1'b0) - 1);
    localparam logic [CW-1:0] L1_ALT  = CW'(gap_first(TD_CLKS, 1'b1) - 1);
    localparam logic [CW-1:0] L2_NORM = CW'(gap_second(TD_CLKS, 1'b0) - 1);
    localparam logic [CW-1:0] L2_ALT  = CW'(gap_second(TD_CLKS, 1'b1) - 1);
    localparam logic [CW-1:0] L3      = CW'(gap_third(TD_CLKS) - 1);

    seq_state_e state, state_nxt;
    logic       alt_q;

    always_comb begin
        state_nxt = state;
        ev        = EV_NONE;
        load      = 1'b0;
        load_val  = '0;
        if (emerg) begin
            ev        = EV_EMERG;
            state_nxt = ST_DONE;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    ev        = EV_T0;
                    state_nxt = ST_RST_LOW;
                    load      = 1'b1;
                    load_val  = alt_mode ? L1_ALT : L1_NORM;
                end
                ST_RST_LOW: if (expired) begin
                    ev        = EV_CLK;
                    state_nxt = ST_CLK_STOP;
                    load      = 1'b1;
                    load_val  = alt_q ? L2_ALT : L2_NORM;
                end
                ST_CLK_STOP: if (expired) begin
                    ev        = EV_IO;
                    state_nxt = ST_IO_LOW;
                    load      = 1'b1;
                    load_val  = L3;
                end
                ST_IO_LOW: if (expired) begin
                    ev        = EV_VCC;
                    state_nxt = ST_DONE;
                end
                ST_DONE: if (rearm && !start) begin
                    state_nxt = ST_IDLE;
                end
                default: state_nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            alt_q <= 1'b0;
        end else begin
            state <= state_nxt;
            if (state == ST_IDLE && start && !emerg) begin
                alt_q <= alt_mode;
            end
        end
    end

    assign done = (state == ST_DONE);
endmodule

// File: rtl/sc_deact_drive.sv
module sc_deact_drive
    import sc_deact_pkg::*;
#(
    parameter logic [1:0] VSEL_ON = 2'b10
) (
    input  logic      clk,
    input  logic      rst,
    input  step_ev_e  ev,
    output card_drv_t drv
);
    always_ff @(posedge clk) begin
        if (rst) begin
            drv <= drv_powered(VSEL_ON);
        end else begin
            drv <= drv_step(drv, ev);
        end
    end
endmodule

// File: rtl/sc_deact_seq.sv
module sc_deact_seq
    import sc_deact_pkg::*;
#(
    parameter int         TD_CLKS = 8,
    parameter logic [1:0] VSEL_ON = 2'b10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_low_req,
    input  logic       pwr_warn_req,
    input  logic       sw_reset_req,
    input  logic       sw_verr_req,
    input  logic       emerg_pf,
    input  logic       alt_clk_mode,
    input  logic       rearm,
    output logic       card_rst,
    output logic       card_clk_en,
    output logic       clk_stop,
    output logic       card_io,
    output logic       io_dis,
    output logic [1:0] vsel,
    output logic       shutdown,
    output logic       seq_done
);
    localparam int NSRC    = 4;
    localparam int MAX_GAP = gap_first(TD_CLKS, 1'b1);
    localparam int CW      = $clog2(MAX_GAP + 1);

    logic          any_req;
    logic          load;
    logic [CW-1:0] load_val;
    logic          expired;
    step_ev_e      ev;
    card_drv_t     drv;

    sc_deact_trig #(.NSRC(NSRC)) u_trig (
        .req     ({sw_verr_req, sw_reset_req, pwr_warn_req, pin_low_req}),
        .any_req (any_req)
    );

    sc_deact_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    sc_deact_fsm #(.TD_CLKS(TD_CLKS), .CW(CW)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (any_req),
        .emerg    (emerg_pf),
        .alt_mode (alt_clk_mode),
        .rearm    (rearm),
        .expired  (expired),
        .load     (load),
        .load_val (load_val),
        .ev       (ev),
        .done     (seq_done)
    );

    sc_deact_drive #(.VSEL_ON(VSEL_ON)) u_drive (
        .clk (clk),
        .rst (rst),
        .ev  (ev),
        .drv (drv)
    );

    assign card_rst    = drv.rst_n;
    assign card_clk_en = drv.clk_en;
    assign clk_stop    = drv.clk_stop;
    assign card_io     = drv.io;
    assign io_dis      = drv.io_dis;
    assign vsel        = drv.vsel;
    assign shutdown    = drv.shutdown;
endmodule

// File: rtl/sc_deact_chk.sv
module sc_deact_chk
    import sc_deact_pkg::*;
#(
    parameter int         TD_CLKS = 8,
    parameter logic [1:0] VSEL_ON = 2'b10
) (
    input logic       clk,
    input logic       rst,
    input logic       pin_low_req,
    input logic       pwr_warn_req,
    input logic       sw_reset_req,
    input logic       sw_verr_req,
    input logic       emerg_pf,
    input logic       alt_clk_mode,
    input logic       rearm,
    input logic       card_rst,
    input logic       card_clk_en,
    input logic       clk_stop,
    input logic       card_io,
    input logic       io_dis,
    input logic [1:0] vsel,
    input logic       shutdown,
    input logic       seq_done
);
    localparam int G1N = gap_first(TD_CLKS, 1'b0);
    localparam int G1A = gap_first(TD_CLKS, 1'b1);
    localparam int G12 = G1N + gap_second(TD_CLKS, 1'b0);
    localparam int GTOT = G12 + gap_third(TD_CLKS);

    logic start;
    logic busy;
    logic alt_c;
    int   c;

    assign start = pin_low_req | pwr_warn_req | sw_reset_req | sw_verr_req;

    // Independent elapsed-time model, measured from T0
    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            alt_c <= 1'b0;
            c     <= 0;
        end else begin
            if (emerg_pf || seq_done) begin
                busy <= 1'b0;
            end else if (!busy && start) begin
                busy  <= 1'b1;
                alt_c <= alt_clk_mode;
            end
            c <= busy ? c + 1 : 0;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (card_rst && card_clk_en && !clk_stop && !card_io && !io_dis
                 && vsel == VSEL_ON && !shutdown && !seq_done));

    // R2
    start_t0_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !seq_done && start && !emerg_pf) |=> (!card_rst && shutdown));

    // R3 R6 R8
    clk_step_time_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(clk_stop) && !$past(emerg_pf)) |-> (c == (alt_c ? G1A : G1N)));

    // R4
    io_low_time_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(card_io) && !$past(emerg_pf)) |-> (c == G12));

    // R5
    vcc_off_time_chk: assert property (@(posedge clk) disable iff (rst)
        ((vsel == 2'b00) && !$past(vsel == 2'b00) && !$past(emerg_pf))
            |-> (c == GTOT && seq_done));

    // R9
    emerg_final_chk: assert property (@(posedge clk) disable iff (rst)
        emerg_pf |=> (seq_done && vsel == 2'b00 && !card_rst && !card_clk_en
                      && clk_stop && io_dis && !card_io && shutdown));

    // R10
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_done && (!rearm || start)) |=> seq_done);

    // R7
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!card_rst && shutdown));
endmodule

bind sc_deact_seq sc_deact_chk #(.TD_CLKS(TD_CLKS), .VSEL_ON(VSEL_ON)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pin_low_req  (pin_low_req),
    .pwr_warn_req (pwr_warn_req),
    .sw_reset_req (sw_reset_req),
    .sw_verr_req  (sw_verr_req),
    .emerg_pf     (emerg_pf),
    .alt_clk_mode (alt_clk_mode),
    .rearm        (rearm),
    .card_rst     (card_rst),
    .card_clk_en  (card_clk_en),
    .clk_stop     (clk_stop),
    .card_io      (card_io),
    .io_dis       (io_dis),
    .vsel         (vsel),
    .shutdown     (shutdown),
    .seq_done     (seq_done)
);

// File: tb/sc_deact_seq_test.sv
module sc_deact_seq_test;
    localparam int TD = 8;
    // Vector layout: {card_rst, card_clk_en, clk_stop, card_io, io_dis, vsel[1:0], shutdown, seq_done}
    localparam logic [8:0] V_RESET  = 9'b1_1_0_0_0_10_0_0;
    localparam logic [8:0] V_FINAL  = 9'b0_0_1_0_1_00_1_1;
    localparam logic [8:0] V_REARMD = 9'b0_0_1_0_1_00_1_0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] req = '0;
    logic emerg_pf = 1'b0;
    logic alt_clk_mode = 1'b0;
    logic rearm = 1'b0;
    logic card_rst, card_clk_en, clk_stop, card_io, io_dis, shutdown, seq_done;
    logic [1:0] vsel;
    logic [8:0] obs;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sc_deact_seq uut (
        .clk          (clk),
        .rst          (rst),
        .pin_low_req  (req[0]),
        .pwr_warn_req (req[1]),
        .sw_reset_req (req[2]),
        .sw_verr_req  (req[3]),
        .emerg_pf     (emerg_pf),
        .alt_clk_mode (alt_clk_mode),
        .rearm        (rearm),
        .card_rst     (card_rst),
        .card_clk_en  (card_clk_en),
        .clk_stop     (clk_stop),
        .card_io      (card_io),
        .io_dis       (io_dis),
        .vsel         (vsel),
        .shutdown     (shutdown),
        .seq_done     (seq_done)
    );

    assign obs = {card_rst, card_clk_en, clk_stop, card_io, io_dis, vsel, shutdown, seq_done};

    task automatic chk(input string tag, input logic [8:0] exp);
        checks++;
        if (obs !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, obs, exp);
        end
    endtask

    // Expected outputs m edges after T0 (edge T0 itself is m=0)
    function automatic logic [8:0] expv(input int m, input int g1, input int g2,
                                        input logic [8:0] base);
        logic [8:0] v;
        v = base;
        if (m >= 0) begin v[8] = 1'b0; v[1] = 1'b1; end
        if (m >= g1) begin v[7] = 1'b0; v[6] = 1'b1; v[5] = 1'b1; v[4] = 1'b1; end
        if (m >= g1 + g2) v[5] = 1'b0;
        if (m >= g1 + g2 + TD) begin v[3:2] = 2'b00; v[0] = 1'b1; end
        return v;
    endfunction

    function automatic string stage_tag(input int m, input int g1, input int g2, input logic alt);
        if (m < g1) return "R2";
        if (alt && m < g1 + g2) return "R6";
        if (m < g1 + g2) return "R3";
        if (m < g1 + g2 + TD) return "R4";
        return "R5";
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req = '0; emerg_pf = 1'b0; rearm = 1'b0; alt_clk_mode = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset values
        do_reset();
        chk("R1 reset state", V_RESET);

        // R2..R6: every start source, both modes, one-cycle request
        for (int src = 0; src < 4; src++) begin
            for (int a = 0; a < 2; a++) begin
                int g1, g2;
                g1 = a ? 44 : 40;
                g2 = a ? 4 : 8;
                do_reset();
                chk("R1 reset state", V_RESET);
                req[src] = 1'b1;
                alt_clk_mode = a[0];
                for (int i = 0; i <= 60; i++) begin
                    @(negedge clk);
                    if (i == 0) req = '0;
                    chk(stage_tag(i, g1, g2, a[0]), expv(i, g1, g2, V_RESET));
                end
            end
        end

        // R7 R8: requests held throughout, mode select flipped mid-sequence
        for (int a = 0; a < 2; a++) begin
            int g1, g2;
            g1 = a ? 44 : 40;
            g2 = a ? 4 : 8;
            do_reset();
            req = 4'b1111;
            alt_clk_mode = a[0];
            for (int i = 0; i <= 65; i++) begin
                @(negedge clk);
                if (i == 10) alt_clk_mode = ~alt_clk_mode;
                if (i == 20) req = 4'b0101;
                if (i == 30) req = 4'b1010;
                chk(i < 56 ? (i == 40 || i == 44 ? "R8" : "R7") : "R7",
                    expv(i, g1, g2, V_RESET));
            end
            req = '0;
        end

        // R9: emergency in idle
        do_reset();
        emerg_pf = 1'b1;
        @(negedge clk);
        emerg_pf = 1'b0;
        chk("R9 emergency from idle", V_FINAL);

        // R9: emergency at every offset of a running sequence
        for (int k = 0; k <= 57; k++) begin
            do_reset();
            req[1] = 1'b1;
            for (int i = 0; i <= k + 1; i++) begin
                @(negedge clk);
                if (i == 0) req = '0;
                if (i == k + 1) chk("R9 emergency mid-sequence", V_FINAL);
                if (i == k) emerg_pf = 1'b1;
            end
            emerg_pf = 1'b0;
            @(negedge clk);
            chk("R9 stays deactivated", V_FINAL);
        end

        // R10: done hold, rearm rules, new sequence
        do_reset();
        req[0] = 1'b1;
        for (int i = 0; i <= 56; i++) begin
            @(negedge clk);
            if (i == 0) req = '0;
        end
        chk("R5 sequence complete", V_FINAL);
        repeat (3) @(negedge clk);
        chk("R10 done holds without rearm", V_FINAL);
        rearm = 1'b1;
        req[2] = 1'b1;
        @(negedge clk);
        chk("R10 rearm with active request ignored", V_FINAL);
        req = '0;
        @(negedge clk);
        rearm = 1'b0;
        chk("R10 rearm clears done only", V_REARMD);
        @(negedge clk);
        chk("R10 idle after rearm", V_REARMD);
        req[3] = 1'b1;
        for (int i = 0; i <= 58; i++) begin
            @(negedge clk);
            if (i == 0) req = '0;
            if (i == 20) rearm = 1'b1;
            if (i == 21) rearm = 1'b0;
            if (i == 55 || i == 56 || i == 58 || i == 22)
                chk("R10 second sequence", expv(i, 40, 8, V_REARMD));
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule